// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

A synchronous memory with two fully independent ports, left and right, each clocked by its own clock. Every port can read or write any word on every cycle. A word is 72 bits wide and split into eight 9-bit lanes. Writes update only the lanes whose active-low byte enables are low. Reads are registered in two stages: the request is taken at one rising edge and the word appears on the read bus after the next one.

The two topmost addresses are reserved as mailboxes for messages between the ports. The top address belongs to the right port and the address below it belongs to the left port. When one port writes into the other port's mailbox, the owner's active-low interrupt output goes low right after the writer's clock edge. When the owner reads its own mailbox, the interrupt returns high right after the reader's clock edge. Both actions count only if at least one byte enable is low. Mailbox words also hold data like any other word. An asynchronous active-low reset puts both interrupts in the inactive state.

Top module: `dp_mailbox_ram`

## Requirements
- R1: While rst_ni is low, and right after it is released, both irq_l_no and irq_r_no are high and both read buses are zero.
- R2: A write changes only the lanes whose be_*_ni bit is 0. Lane k is data bits [9k+8:9k], and bit k of the enable selects lane k. The other lanes keep their previous contents.
- R3: A read taken at rising edge N (ce high, we low) drives the word onto rdata after edge N+1. The read bus does not change after edge N, and it holds its value on cycles with no read.
- R4: A left-port write with at least one enabled lane to address 2^ADDR_W-1 drives irq_r_no low right after that left clock edge.
- R5: A right-port write with at least one enabled lane to address 2^ADDR_W-2 drives irq_l_no low right after that right clock edge.
- R6: A read by the owning port of its own mailbox, with at least one enabled lane, returns that port's interrupt high right after the reader's edge. The owner needs only one such read, however many mailbox writes came before it.
- R7: A port writing its own mailbox raises no interrupt. A port reading the other port's mailbox does not clear the other port's interrupt.
- R8: A mailbox write or read with all eight enables high neither sets nor clears an interrupt. Such a write also leaves the stored word unchanged.
- R9: When a mailbox set and a clear of the same interrupt happen at the same instant, the interrupt stays low.
- R10: When both ports write the same address in the same cycle, lanes enabled by the left port take the left data. Lanes enabled only by the right port take the right data.
- R11: Mailbox words store and return data like normal words.
- R12: A word written by one port is read back unchanged by the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l_i | input | 1 | Left port clock |
| clk_r_i | input | 1 | Right port clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_l_i | input | 1 | Left access enable |
| we_l_i | input | 1 | Left write (1) / read (0) |
| addr_l_i | input | ADDR_W | Left word address |
| be_l_ni | input | LANES | Left lane enables, active low |
| wdata_l_i | input | LANES*LANE_W | Left write data |
| rdata_l_o | output | LANES*LANE_W | Left read data |
| irq_l_no | output | 1 | Left mailbox interrupt, active low |
| ce_r_i | input | 1 | Right access enable |
| we_r_i | input | 1 | Right write (1) / read (0) |
| addr_r_i | input | ADDR_W | Right word address |
| be_r_ni | input | LANES | Right lane enables, active low |
| wdata_r_i | input | LANES*LANE_W | Right write data |
| rdata_r_o | output | LANES*LANE_W | Right read data |
| irq_r_no | output | 1 | Right mailbox interrupt, active low |

## Verification
Storage is split into two banks whose contents are combined with XOR. A lane stored wrongly in either bank therefore shows up as corrupted bits in the next read of that word from either port, two edges after the read request. A wrong mailbox set or acknowledge count moves the interrupt pin in the first cycle after the access that touched it. The bench exercises repeated writes with no read in between, and a set and a clear on the same edge, because a fault in the counter logic shows up only in those cases.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  function automatic op_e decode_op(input logic ce, input logic we);
    if (!ce) return OP_IDLE;
    return we ? OP_WRITE : OP_READ;
  endfunction

endpackage

// File: rtl/dpm_bank.sv
// One write port, three combinational read ports. The stored word is one XOR share.
module dpm_bank #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 8,
  parameter int LANE_W = 9
) (
  input  logic                     clk_i,
  input  logic [LANES-1:0]         lane_en_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic [LANES*LANE_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0]        x_addr_i,
  output logic [LANES*LANE_W-1:0]  x_rdata_o,
  input  logic [ADDR_W-1:0]        ra_addr_i,
  output logic [LANES*LANE_W-1:0]  ra_rdata_o,
  input  logic [ADDR_W-1:0]        rb_addr_i,
  output logic [LANES*LANE_W-1:0]  rb_rdata_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = LANES * LANE_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < LANES; k++) begin
      if (lane_en_i[k]) mem[waddr_i][k*LANE_W +: LANE_W] <= wdata_i[k*LANE_W +: LANE_W];
    end
  end

  assign x_rdata_o  = mem[x_addr_i];
  assign ra_rdata_o = mem[ra_addr_i];
  assign rb_rdata_o = mem[rb_addr_i];

endmodule

// File: rtl/dpm_mbx_flag.sv
// Interrupt flag shared by two clock domains: set count in the writer domain, ack count in the reader domain.
module dpm_mbx_flag (
  input  logic clk_set_i,
  input  logic clk_clr_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic [1:0] set_cnt_q, ack_cnt_q, set_nxt;

  // next set count differs from both the old set count and the current ack, so a coincident ack cannot cancel it
  always_comb begin
    set_nxt = set_cnt_q + 2'd1;
    if (set_nxt == ack_cnt_q) set_nxt = set_cnt_q + 2'd2;
  end

  always_ff @(posedge clk_set_i or negedge rst_ni) begin
    if (!rst_ni)    set_cnt_q <= '0;
    else if (set_i) set_cnt_q <= set_nxt;
  end

  always_ff @(posedge clk_clr_i or negedge rst_ni) begin
    if (!rst_ni)    ack_cnt_q <= '0;
    else if (clr_i) ack_cnt_q <= set_cnt_q;
  end

  assign flag_o = (set_cnt_q != ack_cnt_q);

  // R4 / R5 / R9: a set is visible right after the writer's edge, even with a coincident clear
  a_r9_set_wins: assert property (@(posedge clk_set_i) disable iff (!rst_ni) set_i |=> flag_o);

endmodule

// File: rtl/dpm_port.sv
// Per-port decode and two-stage registered read.
module dpm_port
  import dpm_pkg::*;
#(
  parameter int                ADDR_W   = 10,
  parameter int                LANES    = 8,
  parameter int                LANE_W   = 9,
  parameter logic [ADDR_W-1:0] OWN_MBX  = '1,
  parameter logic [ADDR_W-1:0] PEER_MBX = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ce_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [LANES-1:0]         be_ni,
  input  logic [LANES*LANE_W-1:0]  rd_word_i,
  output logic [LANES-1:0]         wr_lanes_o,
  output logic [ADDR_W-1:0]        rd_addr_o,
  output logic                     own_clr_o,
  output logic                     peer_set_o,
  output logic [LANES*LANE_W-1:0]  rdata_o
);
  op_e  op;
  logic be_hit;
  logic rd_v_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [LANES*LANE_W-1:0] rdata_q;

  assign op         = decode_op(ce_i, we_i);
  assign be_hit     = |(~be_ni);
  assign wr_lanes_o = (op == OP_WRITE) ? ~be_ni : '0;
  assign peer_set_o = (op == OP_WRITE) && (addr_i == PEER_MBX) && be_hit;
  assign own_clr_o  = (op == OP_READ)  && (addr_i == OWN_MBX)  && be_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_v_q    <= 1'b0;
      rd_addr_q <= '0;
      rdata_q   <= '0;
    end else begin
      rd_v_q <= (op == OP_READ);
      if (op == OP_READ) rd_addr_q <= addr_i;
      if (rd_v_q)        rdata_q   <= rd_word_i;
    end
  end

  assign rd_addr_o = rd_addr_q;
  assign rdata_o   = rdata_q;

  // R3: read bus moves only one edge after a read was taken
  a_r3_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_v_q) |-> $stable(rdata_o));

endmodule

// File: rtl/dp_mailbox_ram.sv
module dp_mailbox_ram #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 8,
  parameter int LANE_W = 9
) (
  input  logic                     clk_l_i,
  input  logic                     clk_r_i,
  input  logic                     rst_ni,
  input  logic                     ce_l_i,
  input  logic                     we_l_i,
  input  logic [ADDR_W-1:0]        addr_l_i,
  input  logic [LANES-1:0]         be_l_ni,
  input  logic [LANES*LANE_W-1:0]  wdata_l_i,
  output logic [LANES*LANE_W-1:0]  rdata_l_o,
  output logic                     irq_l_no,
  input  logic                     ce_r_i,
  input  logic                     we_r_i,
  input  logic [ADDR_W-1:0]        addr_r_i,
  input  logic [LANES-1:0]         be_r_ni,
  input  logic [LANES*LANE_W-1:0]  wdata_r_i,
  output logic [LANES*LANE_W-1:0]  rdata_r_o,
  output logic                     irq_r_no
);
  localparam int                WORD_W = LANES * LANE_W;
  localparam logic [ADDR_W-1:0] MBX_R  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] MBX_L  = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic [LANES-1:0]  lanes_l, lanes_r_raw, lanes_r;
  logic [ADDR_W-1:0] rd_addr_l, rd_addr_r;
  logic [WORD_W-1:0] bl_x, bl_a, bl_b, br_x, br_a, br_b;
  logic [WORD_W-1:0] rd_word_l, rd_word_r;
  logic              set_l, set_r, clr_l, clr_r, flag_l, flag_r;

  dpm_port #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .OWN_MBX(MBX_L), .PEER_MBX(MBX_R)) u_port_l (
    .clk_i(clk_l_i), .rst_ni(rst_ni), .ce_i(ce_l_i), .we_i(we_l_i), .addr_i(addr_l_i),
    .be_ni(be_l_ni), .rd_word_i(rd_word_l), .wr_lanes_o(lanes_l), .rd_addr_o(rd_addr_l),
    .own_clr_o(clr_l), .peer_set_o(set_r), .rdata_o(rdata_l_o));

  dpm_port #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .OWN_MBX(MBX_R), .PEER_MBX(MBX_L)) u_port_r (
    .clk_i(clk_r_i), .rst_ni(rst_ni), .ce_i(ce_r_i), .we_i(we_r_i), .addr_i(addr_r_i),
    .be_ni(be_r_ni), .rd_word_i(rd_word_r), .wr_lanes_o(lanes_r_raw), .rd_addr_o(rd_addr_r),
    .own_clr_o(clr_r), .peer_set_o(set_l), .rdata_o(rdata_r_o));

  // left wins lanes it writes at the same address in the same cycle
  assign lanes_r = lanes_r_raw & ~((addr_r_i == addr_l_i) ? lanes_l : '0);

  // word = bank_l ^ bank_r; each port writes its share XORed with the other bank's content
  dpm_bank #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_bank_l (
    .clk_i(clk_l_i), .lane_en_i(lanes_l), .waddr_i(addr_l_i), .wdata_i(wdata_l_i ^ br_x),
    .x_addr_i(addr_r_i), .x_rdata_o(bl_x),
    .ra_addr_i(rd_addr_l), .ra_rdata_o(bl_a),
    .rb_addr_i(rd_addr_r), .rb_rdata_o(bl_b));

  dpm_bank #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_bank_r (
    .clk_i(clk_r_i), .lane_en_i(lanes_r), .waddr_i(addr_r_i), .wdata_i(wdata_r_i ^ bl_x),
    .x_addr_i(addr_l_i), .x_rdata_o(br_x),
    .ra_addr_i(rd_addr_l), .ra_rdata_o(br_a),
    .rb_addr_i(rd_addr_r), .rb_rdata_o(br_b));

  assign rd_word_l = bl_a ^ br_a;
  assign rd_word_r = bl_b ^ br_b;

  dpm_mbx_flag u_flag_l (
    .clk_set_i(clk_r_i), .clk_clr_i(clk_l_i), .rst_ni(rst_ni),
    .set_i(set_l), .clr_i(clr_l), .flag_o(flag_l));

  dpm_mbx_flag u_flag_r (
    .clk_set_i(clk_l_i), .clk_clr_i(clk_r_i), .rst_ni(rst_ni),
    .set_i(set_r), .clr_i(clr_r), .flag_o(flag_r));

  assign irq_l_no = ~flag_l;
  assign irq_r_no = ~flag_r;

  // R7: an inactive interrupt only falls on a peer-mailbox write from the other port
  a_r7_no_spurious_r: assert property (@(posedge clk_l_i) disable iff (!rst_ni)
    (irq_r_no && !set_r) |=> irq_r_no);
  a_r7_no_spurious_l: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    (irq_l_no && !set_l) |=> irq_l_no);
  // R8: all lanes disabled never raises the peer interrupt
  a_r8_no_lane_no_set: assert property (@(posedge clk_l_i) disable iff (!rst_ni)
    ((&be_l_ni) && irq_r_no) |=> irq_r_no);

endmodule

// File: tb/dp_mailbox_ram_test.sv
module dp_mailbox_ram_test;
  localparam int PERIOD = 10;
  localparam int AW     = 10;
  localparam int LN     = 8;
  localparam int LW     = 9;
  localparam int WW     = LN * LW;
  localparam logic [AW-1:0] MR = {AW{1'b1}};
  localparam logic [AW-1:0] ML = {{(AW-1){1'b1}}, 1'b0};

  typedef logic [WW-1:0] word_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic ce_l, we_l, ce_r, we_r;
  logic [AW-1:0] addr_l, addr_r;
  logic [LN-1:0] be_l, be_r;
  word_t wd_l, wd_r, rdata_l, rdata_r;
  logic irq_l, irq_r;
  int n_cmp = 0, n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  dp_mailbox_ram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) uut (
    .clk_l_i(clk), .clk_r_i(clk), .rst_ni(rst_ni),
    .ce_l_i(ce_l), .we_l_i(we_l), .addr_l_i(addr_l), .be_l_ni(be_l), .wdata_l_i(wd_l),
    .rdata_l_o(rdata_l), .irq_l_no(irq_l),
    .ce_r_i(ce_r), .we_r_i(we_r), .addr_r_i(addr_r), .be_r_ni(be_r), .wdata_r_i(wd_r),
    .rdata_r_o(rdata_r), .irq_r_no(irq_r));

  task automatic chk(input string req, input word_t act, input word_t exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic word_t merge(input word_t old_w, input word_t new_w, input logic [LN-1:0] be_n);
    word_t m = old_w;
    for (int k = 0; k < LN; k++) if (!be_n[k]) m[k*LW +: LW] = new_w[k*LW +: LW];
    return m;
  endfunction

  task automatic idle();
    ce_l = 0; we_l = 0; addr_l = '0; be_l = '1; wd_l = '0;
    ce_r = 0; we_r = 0; addr_r = '0; be_r = '1; wd_r = '0;
  endtask

  // drive both ports for exactly one rising edge; returns at the following falling edge
  task automatic drive(input logic lce, input logic lwe, input logic [AW-1:0] la, input logic [LN-1:0] lbe, input word_t ld,
                       input logic rce, input logic rwe, input logic [AW-1:0] ra, input logic [LN-1:0] rbe, input word_t rd);
    @(negedge clk);
    ce_l = lce; we_l = lwe; addr_l = la; be_l = lbe; wd_l = ld;
    ce_r = rce; we_r = rwe; addr_r = ra; be_r = rbe; wd_r = rd;
    @(negedge clk);
    idle();
  endtask

  task automatic wr_l(input logic [AW-1:0] a, input logic [LN-1:0] be, input word_t d);
    drive(1, 1, a, be, d, 0, 0, '0, '1, '0);
  endtask
  task automatic wr_r(input logic [AW-1:0] a, input logic [LN-1:0] be, input word_t d);
    drive(0, 0, '0, '1, '0, 1, 1, a, be, d);
  endtask
  task automatic rd_l(input logic [AW-1:0] a, input logic [LN-1:0] be, output word_t q);
    drive(1, 0, a, be, '0, 0, 0, '0, '1, '0);
    @(negedge clk);
    q = rdata_l;
  endtask
  task automatic rd_r(input logic [AW-1:0] a, input logic [LN-1:0] be, output word_t q);
    drive(0, 0, '0, '1, '0, 1, 0, a, be, '0);
    @(negedge clk);
    q = rdata_r;
  endtask

  task automatic t_reset();
    chk("R1 irq_l after reset", word_t'(irq_l), word_t'(1));
    chk("R1 irq_r after reset", word_t'(irq_r), word_t'(1));
    chk("R1 rdata_l after reset", rdata_l, '0);
    chk("R1 rdata_r after reset", rdata_r, '0);
  endtask

  task automatic t_lanes();
    word_t a = 72'h13_579B_DF02_468A_CE11;
    word_t b = 72'hEE_DDCC_BBAA_9988_7766;
    word_t q;
    wr_l(10'd5, 8'h00, a);
    wr_l(10'd5, 8'b1111_0101, b);
    rd_l(10'd5, 8'h00, q);
    chk("R2 lanes 1,3 only", q, merge(a, b, 8'b1111_0101));
    wr_r(10'd5, 8'b0111_1110, ~a);
    rd_r(10'd5, 8'h00, q);
    chk("R2 right lanes 0,7 kept", q, merge(merge(a, b, 8'b1111_0101), ~a, 8'b0111_1110));
    wr_l(10'd20, 8'h00, b);
    rd_r(10'd20, 8'h00, q);
    chk("R12 left write, right read", q, b);
    wr_r(10'd21, 8'h00, a);
    rd_l(10'd21, 8'h00, q);
    chk("R12 right write, left read", q, a);
  endtask

  task automatic t_latency();
    word_t d = 72'hA5_A5A5_5A5A_0F0F_F0F0;
    word_t prev;
    wr_l(10'd6, 8'h00, d);
    prev = rdata_l;
    drive(1, 0, 10'd6, 8'h00, '0, 0, 0, '0, '1, '0);
    chk("R3 no data after request edge", rdata_l, prev);
    @(negedge clk);
    chk("R3 data after second edge", rdata_l, d);
    repeat (3) @(negedge clk);
    chk("R3 hold while idle", rdata_l, d);
  endtask

  task automatic t_l2r();
    word_t d = 72'h0C_0FFE_E0DD_BA11_F00D;
    word_t q;
    wr_l(MR, 8'b1111_1110, d);
    chk("R4 irq_r low after left write", word_t'(irq_r), word_t'(0));
    chk("R4 irq_l untouched", word_t'(irq_l), word_t'(1));
    rd_l(MR, 8'h00, q);
    chk("R7 peer read keeps irq_r", word_t'(irq_r), word_t'(0));
    chk("R11 mailbox lane0 data", q[LW-1:0], word_t'(d[LW-1:0]));
    rd_r(MR, 8'hFF, q);
    chk("R8 no-lane read keeps irq_r", word_t'(irq_r), word_t'(0));
    drive(0, 0, '0, '1, '0, 1, 0, MR, 8'h7F, '0);
    chk("R6 owner read clears irq_r", word_t'(irq_r), word_t'(1));
  endtask

  task automatic t_r2l();
    word_t d = 72'h11_2233_4455_6677_8899;
    word_t q;
    wr_r(ML, 8'h00, d);
    chk("R5 irq_l low after right write", word_t'(irq_l), word_t'(0));
    chk("R5 irq_r untouched", word_t'(irq_r), word_t'(1));
    rd_r(ML, 8'h00, q);
    chk("R7 peer read keeps irq_l", word_t'(irq_l), word_t'(0));
    chk("R11 mailbox word via right", q, d);
    rd_l(ML, 8'h00, q);
    chk("R6 owner read clears irq_l", word_t'(irq_l), word_t'(1));
    chk("R11 mailbox word via left", q, d);
  endtask

  task automatic t_own();
    wr_l(ML, 8'h00, 72'h1);
    chk("R7 own write no irq_l", word_t'(irq_l), word_t'(1));
    chk("R7 own write no irq_r", word_t'(irq_r), word_t'(1));
    wr_r(MR, 8'h00, 72'h2);
    chk("R7 right own write no irq_r", word_t'(irq_r), word_t'(1));
    chk("R7 right own write no irq_l", word_t'(irq_l), word_t'(1));
  endtask

  task automatic t_no_lanes();
    word_t q;
    wr_l(MR, 8'h00, 72'h55);
    rd_r(MR, 8'h00, q);
    wr_l(MR, 8'hFF, 72'hAA);
    chk("R8 no-lane write no irq_r", word_t'(irq_r), word_t'(1));
    rd_l(MR, 8'h00, q);
    chk("R8 no-lane write keeps word", q, 72'h55);
    wr_r(ML, 8'hFF, 72'h1);
    chk("R8 no-lane write no irq_l", word_t'(irq_l), word_t'(1));
  endtask

  task automatic t_race();
    wr_l(MR, 8'h00, 72'h1);
    drive(1, 1, MR, 8'h00, 72'h2, 1, 0, MR, 8'h00, '0);
    chk("R9 set wins over clear (pending)", word_t'(irq_r), word_t'(0));
    drive(0, 0, '0, '1, '0, 1, 0, MR, 8'h00, '0);
    chk("R6 clear after race", word_t'(irq_r), word_t'(1));
    drive(1, 1, MR, 8'h00, 72'h3, 1, 0, MR, 8'h00, '0);
    chk("R9 set wins over clear (idle)", word_t'(irq_r), word_t'(0));
    drive(0, 0, '0, '1, '0, 1, 0, MR, 8'h00, '0);
    for (int i = 0; i < 5; i++) wr_r(ML, 8'h00, word_t'(i));
    chk("R5 irq_l low after repeated writes", word_t'(irq_l), word_t'(0));
    drive(1, 0, ML, 8'h00, '0, 0, 0, '0, '1, '0);
    chk("R6 single read after repeated writes", word_t'(irq_l), word_t'(1));
  endtask

  task automatic t_collide();
    word_t dl = 72'h11_1111_1111_1111_1111;
    word_t dr = 72'hEE_EEEE_EEEE_EEEE_EEEE;
    word_t q, e;
    drive(1, 1, 10'd9, 8'hF0, dl, 1, 1, 10'd9, 8'h00, dr);
    e = merge(dr, dl, 8'hF0);
    rd_l(10'd9, 8'h00, q);
    chk("R10 left wins shared lanes", q, e);
    rd_r(10'd9, 8'h00, q);
    chk("R10 right sees same merge", q, e);
  endtask

  task automatic t_async_reset();
    wr_l(MR, 8'h00, 72'h9);
    wr_r(ML, 8'h00, 72'h9);
    #(PERIOD/4);
    rst_ni = 1'b0;
    #1;
    chk("R1 irq_l high in reset", word_t'(irq_l), word_t'(1));
    chk("R1 irq_r high in reset", word_t'(irq_r), word_t'(1));
    chk("R1 rdata_l zero in reset", rdata_l, '0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 irq_r high after release", word_t'(irq_r), word_t'(1));
  endtask

  initial begin
    #(PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle();
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_lanes();
    t_latency();
    t_l2r();
    t_r2l();
    t_own();
    t_no_lanes();
    t_race();
    t_collide();
    t_async_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule